// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page table from memory, one read after the other. A walk starts when the block is idle and a request arrives. The block takes the top ten bits of the virtual address as an index into the first-level table, whose page-aligned base comes from a root input. If that entry is marked present, the block takes the next ten bits as an index into the second-level table that the entry points to. If that second entry is also present, the block joins the page frame it names with the untouched 12-bit page offset.

The block reports a missing entry at either level as a page fault, and it states which level failed. When the first level faults, the second read is never issued. The memory side is a single request channel with a valid/ready handshake, plus a response channel that returns one 32-bit word. There is never more than one request in flight. Each walk ends with a one-cycle done pulse, after which the walker is idle again.

Top module: `pt2_walker`

## Requirements
- R1: After reset, and after a reset applied in the middle of a walk, `walk_ready` is 1 and `walk_done` and `mem_req_valid` are 0.
- R2: The first read of a walk goes to byte address {root_base[31:12], 12'h000} + 4 × walk_va[31:22]. The low 12 bits of `root_base` are ignored.
- R3: A first-level entry with bit 0 equal to 0 ends the walk in the cycle after its response. That cycle shows `walk_done`=1, `walk_fault`=1 and `walk_fault_lvl`=0, and no second request is made.
- R4: A first-level entry with bit 0 equal to 1 leads, in the next cycle, to a second read at {entry[31:12], 12'h000} + 4 × walk_va[21:12].
- R5: A second-level entry with bit 0 equal to 0 gives, in the cycle after its response, `walk_done`=1, `walk_fault`=1 and `walk_fault_lvl`=1.
- R6: A second-level entry with bit 0 equal to 1 gives, in the cycle after its response, `walk_done`=1, `walk_fault`=0 and `walk_pa` = {entry[31:12], walk_va[11:0]}.
- R7: `walk_done` is high for exactly one cycle, and `walk_ready` is 1 in the cycle that follows it. A request held high across the done cycle is taken in that idle cycle.
- R8: A request stays asserted with an unchanged address until `mem_req_ready` accepts it. After acceptance, `mem_req_valid` stays low until the response has come back.
- R9: A `walk_req` that arrives while a walk is in progress is ignored, and the walk goes on with the address it captured at its start.
- R10: A `mem_rsp_valid` pulse that arrives while no response is awaited is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| walk_req | input | 1 | Start a walk; taken only while walk_ready is 1 |
| walk_va | input | 32 | Virtual address to translate |
| root_base | input | 32 | Base of the first-level table; bits 11:0 are ignored |
| walk_ready | output | 1 | Walker is idle and will take a request |
| mem_req_valid | output | 1 | Read request to page table memory |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Entry word: bit 0 present, bits 31:12 next base |
| walk_done | output | 1 | One-cycle end-of-walk pulse |
| walk_pa | output | 32 | Physical address; meaningful with walk_done when no fault |
| walk_fault | output | 1 | Walk ended in a page fault |
| walk_fault_lvl | output | 1 | Failing level: 0 first, 1 second |

## Verification
Two things can happen in the same cycle: the done pulse that ends one walk, and a request for the next walk. The bench provokes this by holding `walk_req` high through a whole walk. It then expects the done cycle to ignore that request and the very next idle cycle to take it, so that the first-level read of the new walk appears one cycle later. During a stalled first read, the bench also injects a stray response and a second request in the same cycle. It judges that neither of them changes the addresses or the final result.

// File: rtl/xw_pkg.sv
package xw_pkg;

   typedef enum logic [2:0] {
      XW_IDLE = 3'd0,
      XW_RD1  = 3'd1,
      XW_WT1  = 3'd2,
      XW_RD2  = 3'd3,
      XW_WT2  = 3'd4,
      XW_DONE = 3'd5
   } xw_state_e;

   typedef struct packed {
      logic ok;
      logic fault;
      logic lvl;
   } xw_fin_t;

endpackage

// File: rtl/xw_field_split.sv
module xw_field_split #(
   parameter int VA_W   = 32,
   parameter int OFFS_W = 12,
   parameter int IDX1_W = 10,
   parameter int IDX2_W = 10
) (
   input  logic [VA_W-1:0]   va,
   output logic [IDX1_W-1:0] idx1,
   output logic [IDX2_W-1:0] idx2,
   output logic [OFFS_W-1:0] offs
);
   localparam int IDX2_LO = OFFS_W;
   localparam int IDX1_LO = OFFS_W + IDX2_W;

   assign offs = va[OFFS_W-1:0];
   assign idx2 = va[IDX2_LO +: IDX2_W];
   assign idx1 = va[IDX1_LO +: IDX1_W];
endmodule

// File: rtl/xw_entry_addr.sv
module xw_entry_addr #(
   parameter int PA_W      = 32,
   parameter int OFFS_W    = 12,
   parameter int IDX_W     = 10,
   parameter int PTE_SHIFT = 2
) (
   input  logic [PA_W-OFFS_W-1:0] base_pfn,
   input  logic [IDX_W-1:0]       idx,
   output logic [PA_W-1:0]        addr
);
   localparam int PFN_W = PA_W - OFFS_W;

   logic [PA_W-1:0] base_byte;
   logic [PA_W-1:0] idx_off;

   assign base_byte = {base_pfn, {OFFS_W{1'b0}}};

   generate
      if (IDX_W + PTE_SHIFT <= OFFS_W) begin : g_concat
         // whole table fits inside one page: no carry into the frame bits
         assign idx_off = PA_W'({idx, {PTE_SHIFT{1'b0}}});
         assign addr    = {base_pfn, idx_off[OFFS_W-1:0]};
      end else begin : g_add
         assign idx_off = PA_W'(idx) << PTE_SHIFT;
         assign addr    = base_byte + idx_off;
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{base_byte, idx_off, PFN_W[0]};
endmodule

// File: rtl/xw_seq.sv
module xw_seq
   import xw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      mem_req_ready,
   input  logic      mem_rsp_valid,
   input  logic      rsp_present,
   output xw_state_e st,
   output logic      take_walk,
   output logic      take_l1,
   output xw_fin_t   fin,
   output logic      fin_en
);
   xw_state_e st_nx;

   always_comb begin
      st_nx     = st;
      take_walk = 1'b0;
      take_l1   = 1'b0;
      fin_en    = 1'b0;
      fin       = '0;
      unique case (st)
         XW_IDLE: if (start) begin
            take_walk = 1'b1;
            st_nx     = XW_RD1;
         end
         XW_RD1: if (mem_req_ready) st_nx = XW_WT1;
         XW_WT1: if (mem_rsp_valid) begin
            if (rsp_present) begin
               take_l1 = 1'b1;
               st_nx   = XW_RD2;
            end else begin
               fin_en    = 1'b1;
               fin.fault = 1'b1;
               fin.lvl   = 1'b0;
               st_nx     = XW_DONE;
            end
         end
         XW_RD2: if (mem_req_ready) st_nx = XW_WT2;
         XW_WT2: if (mem_rsp_valid) begin
            fin_en    = 1'b1;
            fin.ok    = rsp_present;
            fin.fault = !rsp_present;
            fin.lvl   = 1'b1;
            st_nx     = XW_DONE;
         end
         XW_DONE: st_nx = XW_IDLE;
         default: st_nx = XW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= XW_IDLE;
      else        st <= st_nx;
   end
endmodule

// File: rtl/xw_result.sv
module xw_result
   import xw_pkg::*;
#(
   parameter int PA_W   = 32,
   parameter int OFFS_W = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fin_en,
   input  xw_fin_t                fin,
   input  logic [PA_W-OFFS_W-1:0] pfn,
   input  logic [OFFS_W-1:0]      offs,
   output logic [PA_W-1:0]        pa,
   output logic                   fault,
   output logic                   fault_lvl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa        <= '0;
         fault     <= 1'b0;
         fault_lvl <= 1'b0;
      end else if (fin_en) begin
         pa        <= fin.ok ? {pfn, offs} : '0;
         fault     <= fin.fault;
         fault_lvl <= fin.lvl;
      end
   end
endmodule

// File: rtl/pt2_walker.sv
module pt2_walker
   import xw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PTE_W     = 32,
   parameter int OFFS_W    = 12,
   parameter int IDX1_W    = 10,
   parameter int IDX2_W    = 10,
   parameter int VALID_BIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             walk_req,
   input  logic [VA_W-1:0]  walk_va,
   input  logic [PA_W-1:0]  root_base,
   output logic             walk_ready,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             walk_done,
   output logic [PA_W-1:0]  walk_pa,
   output logic             walk_fault,
   output logic             walk_fault_lvl
);
   localparam int PFN_W     = PA_W - OFFS_W;
   localparam int PTE_SHIFT = $clog2(PTE_W / 8);

   initial begin
      if (VA_W != OFFS_W + IDX1_W + IDX2_W)
         $fatal(1, "pt2_walker: index and offset widths must sum to VA_W");
      if (PTE_W < PFN_W + OFFS_W)
         $fatal(1, "pt2_walker: entry too narrow for a frame number");
      if (VALID_BIT >= OFFS_W)
         $fatal(1, "pt2_walker: present bit must lie below the frame field");
      if ((PTE_W % 8) != 0 || (1 << PTE_SHIFT) * 8 != PTE_W)
         $fatal(1, "pt2_walker: entry width must be a power-of-two byte count");
   end

   xw_state_e st;
   logic      take_walk, take_l1, fin_en;
   xw_fin_t   fin;

   logic [VA_W-1:0]   va_q;
   logic [PFN_W-1:0]  root_q, l2base_q;
   logic [IDX1_W-1:0] idx1;
   logic [IDX2_W-1:0] idx2;
   logic [OFFS_W-1:0] offs;
   logic [PA_W-1:0]   addr_l1, addr_l2;
   logic [PFN_W-1:0]  rsp_pfn;
   logic              rsp_present;

   assign rsp_pfn     = mem_rsp_data[OFFS_W +: PFN_W];
   assign rsp_present = mem_rsp_data[VALID_BIT];

   xw_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (walk_req),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .rsp_present   (rsp_present),
      .st            (st),
      .take_walk     (take_walk),
      .take_l1       (take_l1),
      .fin           (fin),
      .fin_en        (fin_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q     <= '0;
         root_q   <= '0;
         l2base_q <= '0;
      end else begin
         if (take_walk) begin
            va_q   <= walk_va;
            root_q <= root_base[PA_W-1:OFFS_W];
         end
         if (take_l1) l2base_q <= rsp_pfn;
      end
   end

   xw_field_split #(
      .VA_W(VA_W), .OFFS_W(OFFS_W), .IDX1_W(IDX1_W), .IDX2_W(IDX2_W)
   ) u_split (
      .va(va_q), .idx1(idx1), .idx2(idx2), .offs(offs)
   );

   xw_entry_addr #(
      .PA_W(PA_W), .OFFS_W(OFFS_W), .IDX_W(IDX1_W), .PTE_SHIFT(PTE_SHIFT)
   ) u_ea1 (
      .base_pfn(root_q), .idx(idx1), .addr(addr_l1)
   );

   xw_entry_addr #(
      .PA_W(PA_W), .OFFS_W(OFFS_W), .IDX_W(IDX2_W), .PTE_SHIFT(PTE_SHIFT)
   ) u_ea2 (
      .base_pfn(l2base_q), .idx(idx2), .addr(addr_l2)
   );

   assign mem_req_valid = (st == XW_RD1) || (st == XW_RD2);
   assign mem_req_addr  = (st == XW_RD2) ? addr_l2 : addr_l1;
   assign walk_ready    = (st == XW_IDLE);
   assign walk_done     = (st == XW_DONE);

   xw_result #(.PA_W(PA_W), .OFFS_W(OFFS_W)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .fin_en    (fin_en),
      .fin       (fin),
      .pfn       (rsp_pfn),
      .offs      (offs),
      .pa        (walk_pa),
      .fault     (walk_fault),
      .fault_lvl (walk_fault_lvl)
   );

   logic unused_in;
   assign unused_in = ^{root_base[OFFS_W-1:0], mem_rsp_data};
endmodule

// File: rtl/xw_check.sv
module xw_check
   import xw_pkg::*;
#(
   parameter int PA_W      = 32,
   parameter int PTE_W     = 32,
   parameter int OFFS_W    = 12,
   parameter int VALID_BIT = 0
) (
   input logic             clk,
   input logic             rst_n,
   input xw_state_e        st,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic             mem_rsp_valid,
   input logic [PTE_W-1:0] mem_rsp_data,
   input logic             walk_ready,
   input logic             walk_done,
   input logic [PA_W-1:0]  walk_pa,
   input logic             walk_fault,
   input logic             walk_fault_lvl
);
   localparam int PFN_W = PA_W - OFFS_W;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid); // R8

   AST_L1_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == XW_WT1) && mem_rsp_valid && !mem_rsp_data[VALID_BIT]
      |=> walk_done && walk_fault && !walk_fault_lvl && !mem_req_valid); // R3

   AST_L2_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == XW_WT1) && mem_rsp_valid && mem_rsp_data[VALID_BIT]
      |=> mem_req_valid && (mem_req_addr[PA_W-1:OFFS_W] == $past(mem_rsp_data[OFFS_W +: PFN_W]))); // R4

   AST_L2_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == XW_WT2) && mem_rsp_valid && !mem_rsp_data[VALID_BIT]
      |=> walk_done && walk_fault && walk_fault_lvl); // R5

   AST_PA_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (st == XW_WT2) && mem_rsp_valid && mem_rsp_data[VALID_BIT]
      |=> walk_done && !walk_fault && (walk_pa[PA_W-1:OFFS_W] == $past(mem_rsp_data[OFFS_W +: PFN_W]))); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |=> !walk_done && walk_ready); // R7

   logic unused_chk;
   assign unused_chk = ^{mem_rsp_data, walk_pa[OFFS_W-1:0]};
endmodule

bind pt2_walker xw_check #(
   .PA_W(PA_W), .PTE_W(PTE_W), .OFFS_W(OFFS_W), .VALID_BIT(VALID_BIT)
) u_xw_check (
   .clk            (clk),
   .rst_n          (rst_n),
   .st             (st),
   .mem_req_valid  (mem_req_valid),
   .mem_req_ready  (mem_req_ready),
   .mem_req_addr   (mem_req_addr),
   .mem_rsp_valid  (mem_rsp_valid),
   .mem_rsp_data   (mem_rsp_data),
   .walk_ready     (walk_ready),
   .walk_done      (walk_done),
   .walk_pa        (walk_pa),
   .walk_fault     (walk_fault),
   .walk_fault_lvl (walk_fault_lvl)
);

// File: tb/pt2_walker_test.sv
`timescale 1ns/1ps
module pt2_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        walk_req = 1'b0;
   logic [31:0] walk_va = '0;
   logic [31:0] root_base = '0;
   logic        walk_ready;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        walk_done;
   logic [31:0] walk_pa;
   logic        walk_fault;
   logic        walk_fault_lvl;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pt2_walker uut (
      .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_va(walk_va),
      .root_base(root_base), .walk_ready(walk_ready),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .walk_done(walk_done), .walk_pa(walk_pa),
      .walk_fault(walk_fault), .walk_fault_lvl(walk_fault_lvl)
   );

   typedef struct packed {
      logic [31:0] va;
      logic [31:0] root;
      logic [31:0] l1;
      logic [31:0] l2;
      logic [1:0]  stall;
      logic        poke;
      logic        keep;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{32'h12345678, 32'h00100000, 32'h00200001, 32'h00ABC001, 2'd0, 1'b0, 1'b0},
      '{32'hFFC00ABC, 32'h80000000, 32'h00000000, 32'h00000000, 2'd1, 1'b0, 1'b0},
      '{32'h00001FFF, 32'h00005ABC, 32'h12345003, 32'h7777E002, 2'd0, 1'b0, 1'b1},
      '{32'hFFFFFFFF, 32'hFFFFF000, 32'hFFFFF001, 32'hFFFFF001, 2'd2, 1'b0, 1'b0},
      '{32'h00000000, 32'h00000000, 32'h00000FFF, 32'h00001001, 2'd1, 1'b1, 1'b0},
      '{32'h80401234, 32'h3ABCD000, 32'h11111001, 32'h22222FFF, 2'd3, 1'b1, 1'b0}
   };

   task automatic check(input logic ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] ent_addr(input logic [31:0] base, input logic [9:0] idx);
      return {base[31:12], 12'h000} + {20'd0, idx, 2'b00};
   endfunction

   task automatic run_walk(input vec_t v);
      logic [31:0] e1, e2, epa;
      e1  = ent_addr(v.root, v.va[31:22]);
      e2  = ent_addr(v.l1, v.va[21:12]);
      epa = {v.l2[31:12], v.va[11:0]};
      @(negedge clk);
      walk_req = 1'b1; walk_va = v.va; root_base = v.root;
      @(negedge clk);
      if (!v.keep) walk_req = 1'b0;
      check(mem_req_valid && mem_req_addr == e1, "R2 first read address", mem_req_addr, e1);
      for (int i = 0; i < int'(v.stall); i++) begin
         if (v.poke && i == 0) begin
            // R9 R10: stray request and stray response while the first read stalls
            mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0;
            walk_req = 1'b1; walk_va = ~v.va;
         end
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         walk_va = v.va;
         if (!v.keep) walk_req = 1'b0;
         check(mem_req_valid && mem_req_addr == e1, "R8 R10 request held", mem_req_addr, e1);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      check(!mem_req_valid, "R8 quiet while waiting", {31'd0, mem_req_valid}, 32'd0);
      for (int i = 0; i < int'(v.stall); i++) begin
         @(negedge clk);
         check(!mem_req_valid && !walk_done, "R8 wait", {31'd0, mem_req_valid}, 32'd0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = v.l1;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!v.l1[0]) begin
         check(walk_done && walk_fault && !walk_fault_lvl && !mem_req_valid,
               "R3 first-level fault", {29'd0, walk_done, walk_fault, walk_fault_lvl}, 32'd6);
      end else begin
         check(mem_req_valid && mem_req_addr == e2, "R4 second read address", mem_req_addr, e2);
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0;
         mem_rsp_valid = 1'b1; mem_rsp_data = v.l2;
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (!v.l2[0])
            check(walk_done && walk_fault && walk_fault_lvl, "R5 second-level fault",
                  {29'd0, walk_done, walk_fault, walk_fault_lvl}, 32'd7);
         else begin
            check(walk_done && !walk_fault, "R6 done without fault",
                  {30'd0, walk_done, walk_fault}, 32'd2);
            check(walk_pa == epa, "R6 R9 physical address", walk_pa, epa);
         end
      end
      @(negedge clk);
      check(!walk_done && walk_ready, "R7 single done pulse then idle",
            {30'd0, walk_done, walk_ready}, 32'd1);
      if (v.keep) begin
         // R7: request held across done is taken in the idle cycle
         @(negedge clk);
         walk_req = 1'b0;
         check(mem_req_valid && mem_req_addr == e1, "R7 back-to-back start", mem_req_addr, e1);
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0;
         mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0;
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         check(walk_done && walk_fault && !walk_fault_lvl, "R3 fault on follow-on walk",
               {29'd0, walk_done, walk_fault, walk_fault_lvl}, 32'd6);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(walk_ready && !walk_done && !mem_req_valid, "R1 reset state",
            {29'd0, walk_ready, walk_done, mem_req_valid}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);
      check(walk_ready && !walk_done && !mem_req_valid, "R1 idle after reset",
            {29'd0, walk_ready, walk_done, mem_req_valid}, 32'd4);

      for (int k = 0; k < NV; k++) run_walk(VECS[k]);

      // R1: reset in the middle of a walk
      @(negedge clk);
      walk_req = 1'b1; walk_va = 32'hCAFE1234; root_base = 32'h00040000;
      @(negedge clk);
      walk_req = 1'b0;
      check(mem_req_valid, "R1 walk under way", {31'd0, mem_req_valid}, 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      check(walk_ready && !walk_done && !mem_req_valid, "R1 mid-walk reset",
            {29'd0, walk_ready, walk_done, mem_req_valid}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);
      run_walk('{32'hCAFE1234, 32'h00040000, 32'h00050001, 32'h00060001, 2'd0, 1'b0, 1'b0});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule